// File: doc/BRIEF.md
# Multi-cycle single-precision floating-point adder

The block adds two binary floating-point words in the standard single-precision layout: a sign bit, a biased exponent field (bias 127 for the default 8-bit field) and a fraction field with an implied leading one. A request is made by pulsing `start` with both operands while `busy` is low. The block then works through an explicit loop: it orders the operands by magnitude, shifts the smaller significand right to line up the exponents, adds or subtracts, normalizes one bit per cycle, rounds to nearest-even, and goes back to normalization when rounding carries out of the significand. It flags exponent overflow and underflow. Field widths are parameters, so a narrow format can share the same logic.

The controller has six states. IDLE waits for `start`, latches the operands larger-magnitude first and moves to ALIGN. ALIGN shifts the smaller significand and keeps two extra bits (guard and round) plus a sticky bit, then moves to ADD. ADD forms the sum or difference and moves to NORM. NORM stays in NORM while it shifts the sum right (carry out) or left (leading one missing). It goes to DONE when the sum is exactly zero and to ROUND once the sum is normalized. ROUND goes to DONE on underflow, back to NORM when rounding overflows the significand, and otherwise to DONE with the packed result. DONE raises `valid` for one cycle and returns to IDLE.

Top module: `fpadd`

## Requirements
- R1: For operands with exponent fields from 1 to all-ones minus one, `sum` equals the exact sum rounded to the nearest representable value, with ties going to the value whose fraction LSB is 0. The sign is bit 31, the exponent is bits 30:23 and the fraction is bits 22:0 in the default format. Example: 0xBF400000 is -0.75.
- R2: Alignment keeps guard and round bits and a sticky OR of every bit shifted out below them. A smaller operand worth just over half an ULP of the larger one rounds up, and one worth exactly half rounds to even.
- R3: When the signs differ, the smaller magnitude is subtracted from the larger one and the result takes the sign of the larger-magnitude operand.
- R4: An exact zero result is the all-zero word (+0), with `ovf` and `unf` low. This holds for -0 + -0 as well.
- R5: An operand whose exponent field is 0 counts as zero, whatever its fraction.
- R6: When rounding carries out of the significand, the result is renormalized: the exponent goes up by one and the fraction becomes 0.
- R7: If the normalized, rounded exponent reaches the all-ones value, `ovf` is 1, `unf` is 0 and `sum` is the sign followed by an all-ones exponent and a zero fraction.
- R8: If the normalized exponent falls below 1, `unf` is 1, `ovf` is 0 and `sum` is all zeros.
- R9: `start` is taken only while `busy` is low, and `busy` is high in the following cycle. A `start` seen while `busy` is high has no effect on the result in progress.
- R10: `valid` is high for exactly one cycle per accepted request. `sum`, `ovf` and `unf` hold their values until the next request completes.
- R11: After reset, `busy`, `valid`, `ovf` and `unf` are 0 and `sum` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse; taken only while busy is low |
| op_a | input | EXP_W+FRAC_W+1 | First operand |
| op_b | input | EXP_W+FRAC_W+1 | Second operand |
| busy | output | 1 | High from the cycle after acceptance through the valid cycle |
| valid | output | 1 | One-cycle pulse marking a finished result |
| sum | output | EXP_W+FRAC_W+1 | Rounded sum, held until the next completion |
| ovf | output | 1 | Exponent overflow on the held result |
| unf | output | 1 | Exponent underflow on the held result |

## Verification
The checker assumes that `start` only means something while `busy` is low, and that operands do not use the all-ones exponent as an input, since infinities and NaNs are not modelled. Under those conditions it expects an overflow word whenever `ovf` is set, an all-zero word on underflow or on any result with a zero exponent field, and held outputs while idle. The exhaustive sweep runs a 3-bit-exponent, 2-bit-fraction instance over every operand pair, including zero-exponent operands with nonzero fractions, but never feeds it an all-ones exponent. The bench drives `start` only from the idle state, except in the one test that checks a `start` issued while the block is busy.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_ADD,
        ST_NORM,
        ST_ROUND,
        ST_DONE
    } fpadd_state_e;

endpackage

// File: rtl/fpadd_align.sv
// Right shift of the smaller significand with guard, round and sticky.
module fpadd_align #(
    parameter int SIG_W = 24,
    parameter int SH_W  = 8
) (
    input  logic [SIG_W-1:0] sig_in,
    input  logic [SH_W-1:0]  shamt,
    output logic [SIG_W+2:0] aligned
);
    localparam int XW = SIG_W + 2;

    logic [XW-1:0] ext;
    logic [XW-1:0] kept;
    logic [XW-1:0] lost_mask;
    logic [31:0]   sh32;
    logic          sticky;

    always_comb begin
        ext  = {sig_in, 2'b00};
        sh32 = 32'(shamt);
        if (sh32 >= 32'(XW)) begin
            kept      = '0;
            lost_mask = '1;
        end else begin
            kept      = ext >> sh32;
            lost_mask = ~({XW{1'b1}} << sh32);
        end
        sticky  = |(ext & lost_mask);
        aligned = {kept, sticky};
    end
endmodule

// File: rtl/fpadd_round.sv
// Round-to-nearest-even increment on a normalized accumulator.
module fpadd_round #(
    parameter int ACC_W = 28
) (
    input  logic [ACC_W-1:0] acc_in,
    output logic [ACC_W-1:0] acc_out,
    output logic             carry
);
    logic             inc;
    logic [ACC_W-4:0] body;

    always_comb begin
        inc     = acc_in[2] & (acc_in[1] | acc_in[0] | acc_in[3]);
        body    = {1'b0, acc_in[ACC_W-2:3]} + (ACC_W-3)'(inc);
        acc_out = {body, 3'b000};
        carry   = body[ACC_W-4];
    end
endmodule

// File: rtl/fpadd.sv
module fpadd
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [EXP_W+FRAC_W:0]   op_a,
    input  logic [EXP_W+FRAC_W:0]   op_b,
    output logic                    busy,
    output logic                    valid,
    output logic [EXP_W+FRAC_W:0]   sum,
    output logic                    ovf,
    output logic                    unf
);
    localparam int WORD_W  = EXP_W + FRAC_W + 1;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int ACC_W   = SIG_W + 4;
    localparam int EXW     = EXP_W + $clog2(ACC_W) + 2;
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam logic signed [EXW-1:0] EXP_ONE = EXW'(1);
    localparam logic signed [EXW-1:0] EXP_TOP = EXW'(EXP_MAX);

    fpadd_state_e state, state_nx;

    logic                    big_s;
    logic [EXP_W-1:0]        big_e, sml_e;
    logic [SIG_W-1:0]        big_sig, sml_sig;
    logic                    eff_sub;
    logic [SIG_W+2:0]        sml_al;
    logic [SIG_W+2:0]        sml_al_nx;
    logic [ACC_W-1:0]        acc;
    logic signed [EXW-1:0]   exp_r;
    logic [ACC_W-1:0]        rnd_acc;
    logic                    rnd_carry;
    logic [WORD_W-1:0]       sum_r;
    logic                    ovf_r, unf_r;

    // operand ordering at request time
    logic                    a_big;
    logic [WORD_W-1:0]       op_big, op_sml;

    always_comb begin
        a_big  = op_a[WORD_W-2:0] >= op_b[WORD_W-2:0];
        op_big = a_big ? op_a : op_b;
        op_sml = a_big ? op_b : op_a;
    end

    fpadd_align #(.SIG_W(SIG_W), .SH_W(EXP_W)) u_align (
        .sig_in  (sml_sig),
        .shamt   (big_e - sml_e),
        .aligned (sml_al_nx)
    );

    fpadd_round #(.ACC_W(ACC_W)) u_round (
        .acc_in  (acc),
        .acc_out (rnd_acc),
        .carry   (rnd_carry)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_ALIGN;
            ST_ALIGN: state_nx = ST_ADD;
            ST_ADD:   state_nx = ST_NORM;
            ST_NORM: begin
                if (acc == '0)               state_nx = ST_DONE;
                else if (acc[ACC_W-1])       state_nx = ST_NORM;
                else if (!acc[ACC_W-2])      state_nx = ST_NORM;
                else                         state_nx = ST_ROUND;
            end
            ST_ROUND: begin
                if (exp_r < EXP_ONE)         state_nx = ST_DONE;
                else if (rnd_carry)          state_nx = ST_NORM;
                else                         state_nx = ST_DONE;
            end
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // datapath and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            big_s   <= 1'b0;
            big_e   <= '0;
            sml_e   <= '0;
            big_sig <= '0;
            sml_sig <= '0;
            eff_sub <= 1'b0;
            sml_al  <= '0;
            acc     <= '0;
            exp_r   <= '0;
            sum_r   <= '0;
            ovf_r   <= 1'b0;
            unf_r   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        big_s   <= op_big[WORD_W-1];
                        big_e   <= op_big[WORD_W-2:FRAC_W];
                        sml_e   <= op_sml[WORD_W-2:FRAC_W];
                        big_sig <= (op_big[WORD_W-2:FRAC_W] == '0) ? '0
                                   : {1'b1, op_big[FRAC_W-1:0]};
                        sml_sig <= (op_sml[WORD_W-2:FRAC_W] == '0) ? '0
                                   : {1'b1, op_sml[FRAC_W-1:0]};
                        eff_sub <= op_a[WORD_W-1] ^ op_b[WORD_W-1];
                    end
                end
                ST_ALIGN: begin
                    sml_al <= sml_al_nx;
                    acc    <= {1'b0, big_sig, 3'b000};
                    exp_r  <= EXW'(big_e);
                end
                ST_ADD: begin
                    if (eff_sub) acc <= acc - {1'b0, sml_al};
                    else         acc <= acc + {1'b0, sml_al};
                end
                ST_NORM: begin
                    if (acc == '0) begin
                        sum_r <= '0;
                        ovf_r <= 1'b0;
                        unf_r <= 1'b0;
                    end else if (acc[ACC_W-1]) begin
                        acc   <= {1'b0, acc[ACC_W-1:2], acc[1] | acc[0]};
                        exp_r <= exp_r + EXP_ONE;
                    end else if (!acc[ACC_W-2]) begin
                        acc   <= {acc[ACC_W-2:0], 1'b0};
                        exp_r <= exp_r - EXP_ONE;
                    end
                end
                ST_ROUND: begin
                    if (exp_r < EXP_ONE) begin
                        sum_r <= '0;
                        ovf_r <= 1'b0;
                        unf_r <= 1'b1;
                    end else if (rnd_carry) begin
                        acc <= rnd_acc;
                    end else if (exp_r >= EXP_TOP) begin
                        sum_r <= {big_s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
                        ovf_r <= 1'b1;
                        unf_r <= 1'b0;
                    end else begin
                        sum_r <= {big_s, exp_r[EXP_W-1:0], rnd_acc[ACC_W-3:3]};
                        ovf_r <= 1'b0;
                        unf_r <= 1'b0;
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    assign busy  = (state != ST_IDLE);
    assign valid = (state == ST_DONE);
    assign sum   = sum_r;
    assign ovf   = ovf_r;
    assign unf   = unf_r;

endmodule

// File: rtl/fpadd_chk.sv
module fpadd_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  busy,
    input logic                  valid,
    input logic [EXP_W+FRAC_W:0] sum,
    input logic                  ovf,
    input logic                  unf
);
    a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    a_r9_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r9_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r7_ovf_word: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ovf) |-> (sum[EXP_W+FRAC_W-1:FRAC_W] == '1
                            && sum[FRAC_W-1:0] == '0 && !unf));

    a_r8_unf_word: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && unf) |-> (sum == '0 && !ovf));

    a_r4_zero_form: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && sum[EXP_W+FRAC_W-1:FRAC_W] == '0) |-> (sum == '0));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(sum) && $stable(ovf) && $stable(unf)));
endmodule

bind fpadd fpadd_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .valid (valid),
    .sum   (sum),
    .ovf   (ovf),
    .unf   (unf)
);

// File: tb/fpadd_test.sv
module fpadd_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc   = 0;

    always #2 clk = ~clk;

    // small instance for the exhaustive sweep: 3-bit exponent, 2-bit fraction
    logic       s_start = 1'b0;
    logic [5:0] s_a = '0, s_b = '0;
    logic       s_busy, s_valid, s_ovf, s_unf;
    logic [5:0] s_sum;

    fpadd #(.EXP_W(3), .FRAC_W(2)) uut (
        .clk(clk), .rst_n(rst_n), .start(s_start), .op_a(s_a), .op_b(s_b),
        .busy(s_busy), .valid(s_valid), .sum(s_sum), .ovf(s_ovf), .unf(s_unf)
    );

    // default single-precision instance for directed vectors
    logic        w_start = 1'b0;
    logic [31:0] w_a = '0, w_b = '0;
    logic        w_busy, w_valid, w_ovf, w_unf;
    logic [31:0] w_sum;

    fpadd uut_wide (
        .clk(clk), .rst_n(rst_n), .start(w_start), .op_a(w_a), .op_b(w_b),
        .busy(w_busy), .valid(w_valid), .sum(w_sum), .ovf(w_ovf), .unf(w_unf)
    );

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected below 190000", cyc);
            finish_run();
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // reference: exact integer sum, then nearest-even rounding
    function automatic logic [7:0] ref_add(input logic [5:0] a, input logic [5:0] b);
        longint va, vb, s, mag, q, rem, half;
        int p, k, e;
        logic sg;
        int ea, eb;
        ea = int'(a[4:2]);
        eb = int'(b[4:2]);
        va = (ea == 0) ? 0 : (longint'(4 + int'(a[1:0])) << (ea - 1));
        vb = (eb == 0) ? 0 : (longint'(4 + int'(b[1:0])) << (eb - 1));
        if (a[5]) va = -va;
        if (b[5]) vb = -vb;
        s = va + vb;
        if (s == 0) return 8'h00;
        sg  = (s < 0);
        mag = sg ? -s : s;
        p = 0;
        for (int i = 0; i < 40; i++) if (((mag >> i) & 1) != 0) p = i;
        e = p - 2 + 1;
        if (p > 2) begin
            k    = p - 2;
            q    = mag >> k;
            rem  = mag & ((longint'(1) << k) - 1);
            half = longint'(1) << (k - 1);
            if (rem > half || (rem == half && q[0])) q = q + 1;
            if (q == 8) begin
                q = q >> 1;
                e = e + 1;
            end
        end else begin
            q = mag << (2 - p);
        end
        if (e < 1) return 8'b01_000000;
        if (e >= 7) return {2'b10, sg, 3'b111, 2'b00};
        return {2'b00, sg, e[2:0], q[1:0]};
    endfunction

    task automatic run_small(input logic [5:0] a, input logic [5:0] b,
                             output logic [7:0] res);
        int guard;
        @(negedge clk);
        s_a = a;
        s_b = b;
        s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        guard = 0;
        while (!s_valid && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        res = {s_ovf, s_unf, s_sum};
    endtask

    task automatic run_wide(input logic [31:0] a, input logic [31:0] b,
                            output logic [33:0] res);
        int guard;
        @(negedge clk);
        w_a = a;
        w_b = b;
        w_start = 1'b1;
        @(negedge clk);
        w_start = 1'b0;
        guard = 0;
        while (!w_valid && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        res = {w_ovf, w_unf, w_sum};
    endtask

    task automatic wide_case(input string tag, input logic [31:0] a, input logic [31:0] b,
                             input logic [33:0] exp);
        logic [33:0] r;
        run_wide(a, b, r);
        check(tag, 64'(r), 64'(exp));
    endtask

    initial begin
        logic [7:0]  rs, es;
        logic [33:0] rw;
        string       tag;

        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 busy", 64'(w_busy), 64'(0));
        check("R11 valid", 64'(w_valid), 64'(0));
        check("R11 sum/flags", 64'({w_ovf, w_unf, w_sum}), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R1 main function and test vector
        wide_case("R1 one plus one", 32'h3F800000, 32'h3F800000, {2'b00, 32'h40000000});
        wide_case("R1 neg 0.75 twice", 32'hBF400000, 32'hBF400000, {2'b00, 32'hBFC00000});
        // R3 sign of larger magnitude
        wide_case("R3 -0.75 + 1.0", 32'hBF400000, 32'h3F800000, {2'b00, 32'h3E800000});
        wide_case("R3 0.75 - 1.5", 32'h3F400000, 32'hBFC00000, {2'b00, 32'hBF400000});
        // R2 guard/round/sticky and ties
        wide_case("R2 tie even stays", 32'h3F800000, 32'h33800000, {2'b00, 32'h3F800000});
        wide_case("R2 tie odd rounds up", 32'h3F800001, 32'h33800000, {2'b00, 32'h3F800002});
        wide_case("R2 sticky above half", 32'h3F800000, 32'h33800001, {2'b00, 32'h3F800001});
        wide_case("R2 sticky subtract", 32'h3F800000, 32'hB3800001, {2'b00, 32'h3F7FFFFF});
        wide_case("R2 far shift", 32'h3F800000, 32'h00800000, {2'b00, 32'h3F800000});
        // R6 rounding carry renormalizes
        wide_case("R6 renormalize", 32'h3FFFFFFF, 32'h33800000, {2'b00, 32'h40000000});
        // R4 zero results
        wide_case("R4 cancel", 32'h3F800000, 32'hBF800000, {2'b00, 32'h00000000});
        wide_case("R4 neg zeros", 32'h80000000, 32'h80000000, {2'b00, 32'h00000000});
        // R5 zero exponent field as zero
        wide_case("R5 flushed operand", 32'h00400000, 32'h3F800000, {2'b00, 32'h3F800000});
        // R7 overflow, R8 underflow
        wide_case("R7 overflow", 32'h7F7FFFFF, 32'h7F7FFFFF, {2'b10, 32'h7F800000});
        wide_case("R7 neg overflow", 32'hFF7FFFFF, 32'hFF7FFFFF, {2'b10, 32'hFF800000});
        wide_case("R8 underflow", 32'h00800000, 32'h80C00000, {2'b01, 32'h00000000});

        // R9: start while busy is ignored
        @(negedge clk);
        w_a = 32'h3F800000;
        w_b = 32'h3F800000;
        w_start = 1'b1;
        @(negedge clk);
        check("R9 busy after accept", 64'(w_busy), 64'(1));
        w_a = 32'h40400000;
        w_b = 32'h40400000;
        @(negedge clk);
        @(negedge clk);
        w_start = 1'b0;
        while (!w_valid && cyc < 180000) @(negedge clk);
        check("R9 ignored start", 64'(w_sum), 64'(32'h40000000));
        // R10: valid one cycle, result held
        @(negedge clk);
        check("R10 valid drops", 64'(w_valid), 64'(0));
        repeat (3) @(negedge clk);
        check("R10 sum held", 64'({w_ovf, w_unf, w_sum}), 64'({2'b00, 32'h40000000}));
        check("R10 idle", 64'(w_busy), 64'(0));

        // exhaustive sweep on the small format (R1, R4, R5, R7, R8)
        for (int ia = 0; ia < 64; ia++) begin
            if (ia[4:2] == 3'b111) continue;
            for (int ib = 0; ib < 64; ib++) begin
                if (ib[4:2] == 3'b111) continue;
                run_small(6'(ia), 6'(ib), rs);
                es = ref_add(6'(ia), 6'(ib));
                if (es[7])            tag = "R7 sweep";
                else if (es[6])       tag = "R8 sweep";
                else if (es == 8'h00) tag = "R4 sweep";
                else                  tag = "R1 sweep";
                check(tag, 64'(rs), 64'(es));
            end
        end

        finish_run();
    end
endmodule